// File: doc/BRIEF.md
# Polled Device Command Handshake

This block connects one host controller to several I/O device ports through status bits alone, with no interrupt line. Each device port holds a one-byte data-out register and three status flags: a write flag, a command-ready flag and an error flag. The host holds one shared busy flag. When a device has work, it waits until the host is idle. It then writes its byte, and raises command-ready one clock later.

The host checks one device per clock in round-robin order, whether or not any device needs service. When it finds a device with command-ready set, it claims that device by raising busy. It then reads the command and the byte, and issues them on a one-cycle execute pulse. It waits for a completion strobe, which may arrive any number of cycles later. On completion it releases the device and clears busy in the same clock. The error flag records the outcome of the command. Scanning then resumes at the device after the one just served.

Top module: `poll_handshake_top`

## Requirements
- R1: After synchronous reset, busy, every write, command-ready and error flag, and the execute pulse are 0.
- R2: A device port posts only in a clock where its request is high, host busy reads 0, and its own write and command-ready flags are 0. Posting sets its write flag and captures its data byte.
- R3: Command-ready rises exactly one clock after the write flag rises, and it rises even if busy has risen meanwhile.
- R4: The host examines one device per clock in round-robin order. Busy rises on the clock after the examined device shows command-ready.
- R5: One clock after busy rises, the execute pulse is high for exactly one clock. It carries the device index, the write flag as read (value 1) and the captured byte.
- R6: A completion strobe that arrives after the execute pulse clears the served device's command-ready and write flags and the host busy flag, all on the same clock.
- R7: When the completion strobe arrives, the served device's error flag is set to 1 if the failure input is 1, and cleared to 0 if it is 0.
- R8: A completion strobe that arrives while the host is not waiting on a command changes no flag.
- R9: After a service, scanning restarts at the served index plus one, wrapping from the last device to device 0.
- R10: Devices that post in the same clock are all served, one at a time, in scan order, and no posting is lost.
- R11: While a device's write flag is set, changes on its data input do not alter the byte that is later executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | N_DEV | Per-device request to post a command |
| dev_data | input | N_DEV*8 | Per-device byte offered for posting (device i at bits 8i+7:8i) |
| host_busy | output | 1 | Shared host busy flag |
| dev_write | output | N_DEV | Per-device write flag |
| dev_ready | output | N_DEV | Per-device command-ready flag |
| dev_error | output | N_DEV | Per-device error flag |
| exec_valid | output | 1 | One-cycle execute pulse |
| exec_idx | output | $clog2(N_DEV) | Index of the served device (held until the next claim) |
| exec_wr | output | 1 | Write flag read from the served device |
| exec_data | output | 8 | Byte read from the served device |
| exec_done | input | 1 | Completion strobe for the issued command |
| exec_fail | input | 1 | Failure qualifier, sampled with exec_done |

## Verification
The hardest situation to reach from the ports is a group of devices that post in the same clock while the scan pointer moves on every cycle. In that case the order of service depends on where the pointer happens to be. The stimulus raises two requests on one falling edge while the host is idle. The bench then checks that exactly two execute pulses follow and that they carry distinct indices. A behavioural model compares every flag on every clock. A long phase with random requests, random completion latencies of zero to three cycles, and random failures drives claims that overlap with posting devices.

// File: rtl/poll_pkg.sv
package poll_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        H_SCAN = 2'd0,
        H_READ = 2'd1,
        H_WAIT = 2'd2
    } host_st_e;

    typedef struct packed {
        logic              wr;
        logic [BYTE_W-1:0] data;
    } exec_cmd_t;

    function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/poll_dev_port.sv
module poll_dev_port
    import poll_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              host_busy,
    input  logic [BYTE_W-1:0] din,
    input  logic              clr,
    input  logic              clr_fail,
    output logic              write_bit,
    output logic              ready_bit,
    output logic              err_bit,
    output exec_cmd_t         cmd
);

    logic [BYTE_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            write_bit <= 1'b0;
            ready_bit <= 1'b0;
            err_bit   <= 1'b0;
            data_q    <= '0;
        end else if (clr) begin
            write_bit <= 1'b0;
            ready_bit <= 1'b0;
            err_bit   <= clr_fail;
        end else if (write_bit && !ready_bit) begin
            ready_bit <= 1'b1;
        end else if (req && !host_busy && !write_bit && !ready_bit) begin
            write_bit <= 1'b1;
            data_q    <= din;
        end
    end

    assign cmd.wr   = write_bit;
    assign cmd.data = data_q;

endmodule

// File: rtl/poll_host_fsm.sv
module poll_host_fsm
    import poll_pkg::*;
#(
    parameter int unsigned N_DEV = 4,
    localparam int unsigned IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DEV-1:0] ready_vec,
    input  exec_cmd_t        cmd_arr [N_DEV],
    input  logic             done,
    output logic             busy,
    output logic             exec_valid,
    output logic [IDX_W-1:0] sel,
    output exec_cmd_t        exec_cmd,
    output logic [N_DEV-1:0] clr_vec
);

    host_st_e         st;
    logic [IDX_W-1:0] ptr;
    logic             finish;

    assign finish = (st == H_WAIT) && done;

    always_comb begin
        clr_vec = '0;
        if (finish) clr_vec[sel] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= H_SCAN;
            ptr        <= '0;
            sel        <= '0;
            busy       <= 1'b0;
            exec_valid <= 1'b0;
            exec_cmd   <= '0;
        end else begin
            case (st)
                H_SCAN: begin
                    if (ready_vec[ptr]) begin
                        busy <= 1'b1;
                        sel  <= ptr;
                        st   <= H_READ;
                    end else begin
                        ptr <= IDX_W'(wrap_next(32'(ptr), N_DEV));
                    end
                end
                H_READ: begin
                    exec_valid <= 1'b1;
                    exec_cmd   <= cmd_arr[sel];
                    st         <= H_WAIT;
                end
                H_WAIT: begin
                    exec_valid <= 1'b0;
                    if (done) begin
                        busy <= 1'b0;
                        ptr  <= IDX_W'(wrap_next(32'(sel), N_DEV));
                        st   <= H_SCAN;
                    end
                end
                default: st <= H_SCAN;
            endcase
        end
    end

endmodule

// File: rtl/poll_handshake_top.sv
module poll_handshake_top
    import poll_pkg::*;
#(
    parameter int unsigned N_DEV = 4,
    localparam int unsigned IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_DEV-1:0]        dev_req,
    input  logic [N_DEV*BYTE_W-1:0] dev_data,
    output logic                    host_busy,
    output logic [N_DEV-1:0]        dev_write,
    output logic [N_DEV-1:0]        dev_ready,
    output logic [N_DEV-1:0]        dev_error,
    output logic                    exec_valid,
    output logic [IDX_W-1:0]        exec_idx,
    output logic                    exec_wr,
    output logic [BYTE_W-1:0]       exec_data,
    input  logic                    exec_done,
    input  logic                    exec_fail
);

    exec_cmd_t        cmd_arr [N_DEV];
    exec_cmd_t        exec_cmd;
    logic [N_DEV-1:0] clr_vec;

    for (genvar g = 0; g < N_DEV; g++) begin : g_dev
        poll_dev_port u_port (
            .clk       (clk),
            .rst       (rst),
            .req       (dev_req[g]),
            .host_busy (host_busy),
            .din       (dev_data[g*BYTE_W +: BYTE_W]),
            .clr       (clr_vec[g]),
            .clr_fail  (exec_fail),
            .write_bit (dev_write[g]),
            .ready_bit (dev_ready[g]),
            .err_bit   (dev_error[g]),
            .cmd       (cmd_arr[g])
        );
    end

    poll_host_fsm #(.N_DEV(N_DEV)) u_host (
        .clk        (clk),
        .rst        (rst),
        .ready_vec  (dev_ready),
        .cmd_arr    (cmd_arr),
        .done       (exec_done),
        .busy       (host_busy),
        .exec_valid (exec_valid),
        .sel        (exec_idx),
        .exec_cmd   (exec_cmd),
        .clr_vec    (clr_vec)
    );

    assign exec_wr   = exec_cmd.wr;
    assign exec_data = exec_cmd.data;

endmodule

// File: rtl/poll_handshake_chk.sv
module poll_handshake_chk #(
    parameter int unsigned N_DEV = 4,
    localparam int unsigned IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             host_busy,
    input logic [N_DEV-1:0] dev_write,
    input logic [N_DEV-1:0] dev_ready,
    input logic [N_DEV-1:0] dev_error,
    input logic             exec_valid,
    input logic [IDX_W-1:0] exec_idx,
    input logic             exec_done,
    input logic             exec_fail
);

    for (genvar g = 0; g < N_DEV; g++) begin : g_per_dev
        assert_post_idle_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(dev_write[g]) |-> !$past(host_busy));
        assert_ready_follows_R3: assert property (@(posedge clk) disable iff (rst)
            $rose(dev_write[g]) |=> dev_ready[g]);
    end

    assert_claim_ready_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(host_busy) |-> dev_ready[exec_idx]);

    assert_exec_single_R5: assert property (@(posedge clk) disable iff (rst)
        exec_valid |=> !exec_valid);

    assert_exec_busy_R5: assert property (@(posedge clk) disable iff (rst)
        exec_valid |-> host_busy);

    assert_release_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(host_busy) |-> (!dev_ready[exec_idx] && !dev_write[exec_idx]));

    assert_err_clear_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(host_busy) && !$past(exec_fail)) |-> !dev_error[exec_idx]);

    assert_err_set_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(host_busy) && $past(exec_fail)) |-> dev_error[exec_idx]);

    assert_idle_err_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (!host_busy && !$past(host_busy)) |-> $stable(dev_error));

endmodule

bind poll_handshake_top poll_handshake_chk #(.N_DEV(N_DEV)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .host_busy  (host_busy),
    .dev_write  (dev_write),
    .dev_ready  (dev_ready),
    .dev_error  (dev_error),
    .exec_valid (exec_valid),
    .exec_idx   (exec_idx),
    .exec_done  (exec_done),
    .exec_fail  (exec_fail)
);

// File: tb/poll_handshake_top_tb_top.sv
module poll_handshake_top_tb_top;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] dev_req = '0;
    logic [N*8-1:0] dev_data = '0;
    logic         host_busy, exec_valid, exec_wr;
    logic [N-1:0] dev_write, dev_ready, dev_error;
    logic [1:0]   exec_idx;
    logic [7:0]   exec_data;
    logic         exec_done = 1'b0;
    logic         exec_fail = 1'b0;

    always #2 clk = ~clk;

    poll_handshake_top #(.N_DEV(N)) dut_i (
        .clk(clk), .rst(rst), .dev_req(dev_req), .dev_data(dev_data),
        .host_busy(host_busy), .dev_write(dev_write), .dev_ready(dev_ready),
        .dev_error(dev_error), .exec_valid(exec_valid), .exec_idx(exec_idx),
        .exec_wr(exec_wr), .exec_data(exec_data),
        .exec_done(exec_done), .exec_fail(exec_fail)
    );

    int total = 0;
    int bad   = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_st = 0;      // 0 scan, 1 read, 2 wait
    int m_ptr = 0, m_sel = 0;
    bit m_busy = 0, m_ev = 0, m_ew = 0;
    int m_ed = 0;
    bit m_wr [N];
    bit m_rdy [N];
    bit m_err [N];
    int m_data [N];
    bit started = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_ptr = 0; m_sel = 0; m_busy = 0; m_ev = 0; m_ew = 0; m_ed = 0;
            for (int i = 0; i < N; i++) begin
                m_wr[i] = 0; m_rdy[i] = 0; m_err[i] = 0; m_data[i] = 0;
            end
        end else begin
            bit ob;
            bit ordy [N];
            bit owr [N];
            bit fin;
            int osel;
            ob = m_busy;
            osel = m_sel;
            for (int i = 0; i < N; i++) begin ordy[i] = m_rdy[i]; owr[i] = m_wr[i]; end
            fin = (m_st == 2) && exec_done;
            if (m_st == 0) begin
                if (ordy[m_ptr]) begin m_busy = 1; m_sel = m_ptr; m_st = 1; end
                else m_ptr = (m_ptr + 1) % N;
            end else if (m_st == 1) begin
                m_ev = 1; m_ed = m_data[m_sel]; m_ew = owr[m_sel]; m_st = 2;
            end else begin
                m_ev = 0;
                if (exec_done) begin m_busy = 0; m_ptr = (m_sel + 1) % N; m_st = 0; end
            end
            for (int i = 0; i < N; i++) begin
                if (fin && i == osel) begin
                    m_rdy[i] = 0; m_wr[i] = 0; m_err[i] = exec_fail;
                end else if (owr[i] && !ordy[i]) begin
                    m_rdy[i] = 1;
                end else if (dev_req[i] && !ob && !owr[i] && !ordy[i]) begin
                    m_wr[i] = 1; m_data[i] = int'(dev_data[i*8 +: 8]);
                end
            end
        end
        started = 1;
    end

    int seen [$];

    always @(negedge clk) begin
        if (started) begin
            check(host_busy == m_busy, "R4/R6 busy", host_busy, m_busy);
            check(exec_valid == m_ev, "R5 exec_valid", exec_valid, m_ev);
            for (int i = 0; i < N; i++) begin
                check(dev_write[i] == m_wr[i], $sformatf("R2 write[%0d]", i), dev_write[i], m_wr[i]);
                check(dev_ready[i] == m_rdy[i], $sformatf("R3 ready[%0d]", i), dev_ready[i], m_rdy[i]);
                check(dev_error[i] == m_err[i], $sformatf("R7 error[%0d]", i), dev_error[i], m_err[i]);
            end
            if (exec_valid && m_ev) begin
                check(int'(exec_idx) == m_sel, "R9 exec_idx", exec_idx, m_sel);
                check(int'(exec_data) == m_ed, "R11 exec_data", exec_data, m_ed);
                check(exec_wr == 1'b1, "R5 exec_wr", exec_wr, 1);
            end
            if (exec_valid) seen.push_back(int'(exec_idx));
        end
    end

    // completion responder
    int lat = 1;
    bit fail_next = 0;
    bit responder_on = 1;
    initial begin
        forever begin
            @(negedge clk);
            if (exec_valid && responder_on) begin
                repeat (lat) @(negedge clk);
                exec_done = 1'b1;
                exec_fail = fail_next;
                @(negedge clk);
                exec_done = 1'b0;
                exec_fail = 1'b0;
            end
        end
    end

    task automatic post(input int idx, input logic [7:0] d);
        dev_req[idx] = 1'b1;
        dev_data[idx*8 +: 8] = d;
        @(negedge clk);
        dev_req[idx] = 1'b0;
    endtask

    task automatic run_tests();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(host_busy == 0 && dev_write == 0 && dev_ready == 0 && dev_error == 0 && exec_valid == 0,
              "R1 reset state", {host_busy, dev_ready}, 0);

        // basic service, success
        lat = 2; fail_next = 0;
        seen.delete();
        post(0, 8'hA5);
        dev_data[7:0] = 8'h3C;   // R11: change while posted
        repeat (20) @(negedge clk);
        check(seen.size() == 1 && seen[0] == 0, "R5 single service dev0", seen.size(), 1);

        // failed command sets error
        lat = 0; fail_next = 1;
        post(3, 8'h5A);
        repeat (20) @(negedge clk);
        check(dev_error[3] == 1'b1, "R7 fail sets error", dev_error[3], 1);

        // stray completion while idle
        responder_on = 0;
        exec_done = 1'b1; exec_fail = 1'b0;
        @(negedge clk);
        exec_done = 1'b0;
        repeat (2) @(negedge clk);
        check(dev_error[3] == 1'b1 && host_busy == 1'b0, "R8 stray done ignored", dev_error[3], 1);
        responder_on = 1;

        // success clears error
        lat = 3; fail_next = 0;
        post(3, 8'h11);
        repeat (20) @(negedge clk);
        check(dev_error[3] == 1'b0, "R7 success clears error", dev_error[3], 0);

        // simultaneous posting
        lat = 1; fail_next = 0;
        seen.delete();
        dev_req[1] = 1'b1; dev_data[15:8] = 8'h21;
        dev_req[2] = 1'b1; dev_data[23:16] = 8'h42;
        @(negedge clk);
        dev_req = '0;
        repeat (30) @(negedge clk);
        check(seen.size() == 2, "R10 both served", seen.size(), 2);
        if (seen.size() == 2)
            check(seen[0] != seen[1] && (seen[0] + seen[1]) == 3, "R10 distinct devices", seen[0] + seen[1], 3);

        // random phase
        for (int c = 0; c < 3000; c++) begin
            dev_req = N'($urandom);
            dev_data = {$urandom};
            lat = int'($urandom % 4);
            fail_next = 1'($urandom);
            @(negedge clk);
        end
        dev_req = '0;
        repeat (30) @(negedge clk);
        check(host_busy == 1'b0 && dev_ready == '0, "R6 drained", dev_ready, 0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule